// File: doc/BRIEF.md
# Calendar Real-Time Clock with Self-Disarming Alarm

This block is a calendar clock that sits behind a simple word-addressed register port. It keeps seven binary fields: year (two digits), month, day of month, day of week, hour, minute and second. An external one-second strobe moves the time forward. The oscillator and the prescaler that produce this strobe are outside the block. A bank of alarm fields has the same layout as the time fields. A mask chooses which of those fields take part in the compare. When every selected field equals the running time, the block latches a sticky status flag, raises its interrupt and disarms the alarm.

After reset the clock does not count. Software must first write a fixed series of seven key values, in order, to seven consecutive word addresses. It must then clear a stop bit. To load a new time, software sets the stop bit, writes the fields and clears the stop bit again. All fields change together on one clock edge. If the seconds field reads the same before and after the other fields are read, the fields that were read belong to one instant.

Top module: `rtc_cal_top`

## Requirements
- R1: Seven key writes are required, in this order: 0xC6 to 0x04, 0x9A to 0x08, 0x59 to 0x0C, 0xA3 to 0x10, 0x57 to 0x14, 0x67 to 0x18 and 0xD2 to 0x1C. Any write into the range 0x04..0x1C that does not match the next expected address and the full 32-bit value restarts the series from its first step. Until the series completes, strobes never move the time.
- R2: Bit 0 of address 0x20 is the stop bit. While it is 1 (or the key series is incomplete), strobes are ignored and field writes are accepted. While the clock is running, field writes are ignored.
- R3: On an accepted strobe, seconds and minutes wrap from 59 to 0, hours wrap from 23 to 0 and day of week wraps from 6 to 0. Each wrap carries into the next field, and every field that changes does so on the same edge.
- R4: Day of month returns to 1 after the last day of the current month. April, June, September and November have 30 days. February has 29 days when the year is a non-zero multiple of 4 and 28 days otherwise, including year 0. The other months have 31 days. Month runs 1 to 12.
- R5: After the last day of month 12, month becomes 1 and the year advances, wrapping from 99 to 0.
- R6: After reset the state is as follows: stop bit 1, year 0, month 1, day of month 1, all other time fields 0, alarm control 0, status 0 and irq 0.
- R7: Alarm control is at 0x7C. Bit 0 arms the alarm, and bit i+1 enables the compare of field i (0 year, 1 month, 2 day of month, 3 day of week, 4 hour, 5 minute, 6 second). Alarm fields sit at 0x60+4*i and time fields at 0x40+4*i. The cycle after a strobe has advanced the time, if the alarm is armed and every enabled field matches, the status sets and bit 0 clears. The other mask bits are kept.
- R8: The alarm status is bit 4 of 0x30. It stays set until software writes 1 to that bit. Writing 0 there leaves it set.
- R9: irq is high only while the status is set and the alarm has not been masked since it fired. A write to 0x7C with bit 0 clear masks irq and leaves the status readable.
- R10: Every read returns a zero-extended 32-bit word. A field write keeps the low 7 bits of the data. Unmapped addresses and the key addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-second strobe, one clock wide per second |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
The hardest states to reach from the ports are the rare calendar carries: February of year 0 against February of year 4, the end of a 30-day month and the year wrap from 99. The bench reaches each of them by setting the stop bit, loading the fields to one second before the carry, then clearing the stop bit for exactly one strobe before setting it again. The alarm is exercised the same way. The seconds are loaded just below the alarm value and the clock runs a short burst of strobes. A behavioural reference model predicts the cycle in which the status sets, the arm bit clears and irq rises. A partly matching mask, where the minute field does not match, shows that no false fire occurs.

// File: rtl/rtc_cal_pkg.sv
// Package: shared field indices, widths and calendar helpers for the
// calendar clock. Assumes binary (not BCD) field encoding.
package rtc_cal_pkg;
    localparam int NFIELD = 7;
    localparam int FW     = 7;

    localparam int I_YEAR = 0;
    localparam int I_MON  = 1;
    localparam int I_DOM  = 2;
    localparam int I_DOW  = 3;
    localparam int I_HOUR = 4;
    localparam int I_MIN  = 5;
    localparam int I_SEC  = 6;

    typedef logic [NFIELD-1:0][FW-1:0] cal_t;

    // Key value expected at each step of the unlock series.
    function automatic logic [7:0] unlock_key(input int step);
        case (step)
            0:       return 8'hC6;
            1:       return 8'h9A;
            2:       return 8'h59;
            3:       return 8'hA3;
            4:       return 8'h57;
            5:       return 8'h67;
            default: return 8'hD2;
        endcase
    endfunction

    // Number of days in a month; year 0 is never a leap year.
    function automatic logic [FW-1:0] month_days(input logic [FW-1:0] mon,
                                                 input logic [FW-1:0] yr);
        logic leap;
        leap = (yr[1:0] == 2'b00) && (yr != '0);
        case (mon)
            FW'(2):                      return leap ? FW'(29) : FW'(28);
            FW'(4), FW'(6), FW'(9), FW'(11): return FW'(30);
            default:                     return FW'(31);
        endcase
    endfunction
endpackage

// File: rtl/rtc_unlock.sv
// Module: tracks the key-write series that must finish before the clock
// may count. Assumes keys occupy consecutive word addresses from BASE.
// Any write inside the key window that is not the next expected one
// restarts the series. Once complete, the state holds until reset.
module rtc_unlock #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int BASE   = 4,
    parameter int STEPS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    localparam int SW = $clog2(STEPS + 1);
    localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(BASE + 4 * (STEPS - 1));

    logic [SW-1:0]     step_q;
    logic              in_win;
    logic [ADDR_W-1:0] want_addr;
    logic [DATA_W-1:0] want_data;

    // Decode whether this write lands in the key window and what is expected.
    always_comb begin
        in_win    = wr_en && (addr >= FIRST) && (addr <= LAST) && (addr[1:0] == 2'b00);
        want_addr = FIRST + ADDR_W'({step_q, 2'b00});
        want_data = DATA_W'(rtc_cal_pkg::unlock_key(int'(step_q)));
    end

    assign unlocked = (step_q == SW'(STEPS));

    // Advance on a correct key write, restart on any other key-window write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (in_win && !unlocked) begin
            if (addr == want_addr && wdata == want_data)
                step_q <= step_q + 1'b1;
            else
                step_q <= '0;
        end
    end
endmodule

// File: rtl/rtc_timekeeper.sv
// Module: holds the seven calendar fields and advances them on a strobe.
// Assumes the caller blocks field writes while counting. Compares use >=
// so a loaded out-of-range value still rolls over instead of running away.
module rtc_timekeeper
    import rtc_cal_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          wr_en,
    input  logic [2:0]    wr_idx,
    input  logic [FW-1:0] wr_val,
    output cal_t          time_q
);
    cal_t nxt;

    // Compute the time one second later, carrying through all fields.
    always_comb begin
        nxt = time_q;
        if (time_q[I_SEC] >= FW'(59)) begin
            nxt[I_SEC] = '0;
            if (time_q[I_MIN] >= FW'(59)) begin
                nxt[I_MIN] = '0;
                if (time_q[I_HOUR] >= FW'(23)) begin
                    nxt[I_HOUR] = '0;
                    nxt[I_DOW]  = (time_q[I_DOW] >= FW'(6)) ? '0 : time_q[I_DOW] + 1'b1;
                    if (time_q[I_DOM] >= month_days(time_q[I_MON], time_q[I_YEAR])) begin
                        nxt[I_DOM] = FW'(1);
                        if (time_q[I_MON] >= FW'(12)) begin
                            nxt[I_MON]  = FW'(1);
                            nxt[I_YEAR] = (time_q[I_YEAR] >= FW'(99)) ? '0 : time_q[I_YEAR] + 1'b1;
                        end else begin
                            nxt[I_MON] = time_q[I_MON] + 1'b1;
                        end
                    end else begin
                        nxt[I_DOM] = time_q[I_DOM] + 1'b1;
                    end
                end else begin
                    nxt[I_HOUR] = time_q[I_HOUR] + 1'b1;
                end
            end else begin
                nxt[I_MIN] = time_q[I_MIN] + 1'b1;
            end
        end else begin
            nxt[I_SEC] = time_q[I_SEC] + 1'b1;
        end
    end

    // Field storage: reset to 00-01-01, then advance or accept a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q        <= '0;
            time_q[I_MON] <= FW'(1);
            time_q[I_DOM] <= FW'(1);
        end else if (advance) begin
            time_q <= nxt;
        end else if (wr_en) begin
            time_q[wr_idx] <= wr_val;
        end
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
// Module: alarm fields, arm/mask control, sticky status and interrupt gate.
// Assumes 'advance' pulses in the cycle a strobe is accepted. The compare
// runs one cycle later against the updated time. A fire clears the arm bit.
module rtc_alarm_unit
    import rtc_cal_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  cal_t          time_q,
    input  logic          fld_wr,
    input  logic [2:0]    fld_idx,
    input  logic [FW-1:0] fld_val,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_val,
    input  logic          int_clr,
    output cal_t          al_q,
    output logic [7:0]    al_ctl_q,
    output logic          status_q,
    output logic          irq
);
    logic              adv_d;
    logic              gate_q;
    logic [NFIELD-1:0] hit;
    logic              fire;

    // Per-field compare; a field whose mask bit is clear always agrees.
    for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
        assign hit[i] = !al_ctl_q[i+1] || (al_q[i] == time_q[i]);
    end

    assign fire = adv_d && al_ctl_q[0] && (&hit);
    assign irq  = status_q && gate_q;

    // Remember that the time moved on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) adv_d <= 1'b0;
        else        adv_d <= advance;
    end

    // Alarm field storage, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)      al_q <= '0;
        else if (fld_wr) al_q[fld_idx] <= fld_val;
    end

    // Arm/mask register; a fire drops the arm bit, winning over a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_ctl_q <= '0;
        end else begin
            if (ctl_wr) al_ctl_q <= ctl_val;
            if (fire)   al_ctl_q[0] <= 1'b0;
        end
    end

    // Sticky status and interrupt gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            gate_q   <= 1'b0;
        end else if (fire) begin
            status_q <= 1'b1;
            gate_q   <= 1'b1;
        end else begin
            if (int_clr) status_q <= 1'b0;
            if (int_clr || (ctl_wr && !ctl_val[0])) gate_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_cal_top.sv
// Module: register decode and read mux for the calendar clock. Assumes a
// single-cycle write strobe and a combinational read of reg_addr. Field
// writes are only accepted while the counter is not running.
module rtc_cal_top
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(8'h20);
    localparam logic [ADDR_W-1:0] A_INT   = ADDR_W'(8'h30);
    localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(8'h40);
    localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(8'h60);
    localparam logic [ADDR_W-1:0] A_ALCTL = ADDR_W'(8'h7C);
    localparam int                SPAN    = 4 * (NFIELD - 1);

    logic       stop_q;
    logic       unlocked;
    logic       run;
    logic       tm_hit;
    logic       al_hit;
    logic       t_wr;
    logic       int_clr;
    logic [2:0] idx;
    cal_t       time_q;
    cal_t       al_q;
    logic [7:0] al_ctl_q;
    logic       status_q;

    // Address decode for the two field windows and the control words.
    always_comb begin
        idx     = reg_addr[4:2];
        tm_hit  = (reg_addr >= A_TIME)  && (reg_addr <= A_TIME  + ADDR_W'(SPAN)) && (reg_addr[1:0] == 2'b00);
        al_hit  = (reg_addr >= A_ALARM) && (reg_addr <= A_ALARM + ADDR_W'(SPAN)) && (reg_addr[1:0] == 2'b00);
        run     = unlocked && !stop_q;
        t_wr    = reg_wr && tm_hit && !run;
        int_clr = reg_wr && (reg_addr == A_INT) && reg_wdata[4];
    end

    // Stop bit; set out of reset so the clock starts frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)                             stop_q <= 1'b1;
        else if (reg_wr && reg_addr == A_CTL)   stop_q <= reg_wdata[0];
    end

    rtc_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(4), .STEPS(7)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .unlocked (unlocked)
    );

    rtc_timekeeper u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (run && tick),
        .wr_en   (t_wr),
        .wr_idx  (idx),
        .wr_val  (reg_wdata[FW-1:0]),
        .time_q  (time_q)
    );

    rtc_alarm_unit u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (run && tick),
        .time_q   (time_q),
        .fld_wr   (reg_wr && al_hit),
        .fld_idx  (idx),
        .fld_val  (reg_wdata[FW-1:0]),
        .ctl_wr   (reg_wr && reg_addr == A_ALCTL),
        .ctl_val  (reg_wdata[7:0]),
        .int_clr  (int_clr),
        .al_q     (al_q),
        .al_ctl_q (al_ctl_q),
        .status_q (status_q),
        .irq      (irq)
    );

    // Read mux returning zero-extended words.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTL)        reg_rdata[0]    = stop_q;
        else if (reg_addr == A_INT)   reg_rdata[4]    = status_q;
        else if (reg_addr == A_ALCTL) reg_rdata[7:0]  = al_ctl_q;
        else if (tm_hit)              reg_rdata[FW-1:0] = time_q[idx];
        else if (al_hit)              reg_rdata[FW-1:0] = al_q[idx];
    end
endmodule

// File: rtl/rtc_cal_chk.sv
// Checker: temporal properties of the calendar clock, bound to the top.
module rtc_cal_chk
    import rtc_cal_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic run,
    input logic unlocked,
    input logic t_wr,
    input cal_t time_bus,
    input logic al_en,
    input logic status,
    input logic int_clr,
    input logic irq
);
    // Locked: only a software write may change the time.
    p_locked_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && !t_wr) |=> $stable(time_bus));

    // Stopped: strobes leave the time unchanged.
    p_stopped_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !t_wr) |=> $stable(time_bus));

    // A running strobe below the wrap point adds exactly one second.
    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && time_bus[I_SEC] < FW'(59)) |=> (time_bus[I_SEC] == $past(time_bus[I_SEC]) + 1'b1));

    // A fire disarms the alarm on the same edge that sets the status.
    p_fire_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> !al_en);

    // Status holds until a write-one-to-clear.
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !int_clr) |=> status);

    // The interrupt never appears without the status behind it.
    p_irq_has_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status);
endmodule

bind rtc_cal_top rtc_cal_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (run),
    .unlocked (unlocked),
    .t_wr     (t_wr),
    .time_bus (time_q),
    .al_en    (al_ctl_q[0]),
    .status   (status_q),
    .int_clr  (int_clr),
    .irq      (irq)
);

// File: tb/rtc_cal_top_tb.sv
`timescale 1ns/1ps
module rtc_cal_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_req = "R6";

    always #2.5 clk = ~clk;

    rtc_cal_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // ---------------- reference model ----------------
    int keys[7] = '{'hC6, 'h9A, 'h59, 'hA3, 'h57, 'h67, 'hD2};
    int mt[7];
    int ma[7];
    int malctl, mstat, mgate, mstop, mprog, madvd;

    function automatic int mdim(int mon, int yr);
        bit leap = (yr % 4 == 0) && (yr != 0);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int mread(int a);
        if (a == 'h20) return mstop;
        if (a == 'h30) return mstat * 16;
        if (a == 'h7C) return malctl;
        if (a >= 'h40 && a <= 'h58 && a % 4 == 0) return mt[(a - 'h40) / 4];
        if (a >= 'h60 && a <= 'h78 && a % 4 == 0) return ma[(a - 'h60) / 4];
        return 0;
    endfunction

    always @(posedge clk) begin : model
        int nt[7];
        int na[7];
        int nalctl, nstat, ngate, nstop, nprog;
        bit run, hit, fire;
        int a, wd;
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) begin mt[i] = 0; ma[i] = 0; end
            mt[1] = 1; mt[2] = 1;
            malctl = 0; mstat = 0; mgate = 0; mstop = 1; mprog = 0; madvd = 0;
        end else begin
            a = int'(reg_addr); wd = int'(reg_wdata);
            nt = mt; na = ma; nalctl = malctl; nstat = mstat; ngate = mgate;
            nstop = mstop; nprog = mprog;
            run = (mprog == 7) && (mstop == 0);
            hit = 1'b1;
            for (int i = 0; i < 7; i++)
                if (((malctl >> (i + 1)) & 1) == 1 && ma[i] != mt[i]) hit = 1'b0;
            fire = (madvd == 1) && ((malctl & 1) == 1) && hit;
            if (run && tick) begin
                if (nt[6] < 59) nt[6]++; else begin nt[6] = 0;
                    if (nt[5] < 59) nt[5]++; else begin nt[5] = 0;
                        if (nt[4] < 23) nt[4]++; else begin nt[4] = 0;
                            nt[3] = (nt[3] + 1) % 7;
                            if (nt[2] < mdim(nt[1], nt[0])) nt[2]++; else begin nt[2] = 1;
                                if (nt[1] < 12) nt[1]++; else begin nt[1] = 1; nt[0] = (nt[0] + 1) % 100; end
                            end
                        end
                    end
                end
            end
            if (reg_wr) begin
                if (a >= 4 && a <= 'h1C && a % 4 == 0 && mprog < 7)
                    nprog = (a == 4 + 4 * mprog && reg_wdata == 32'(keys[mprog])) ? mprog + 1 : 0;
                if (a == 'h20) nstop = wd & 1;
                if (a >= 'h40 && a <= 'h58 && a % 4 == 0 && !run) nt[(a - 'h40) / 4] = wd & 127;
                if (a >= 'h60 && a <= 'h78 && a % 4 == 0) na[(a - 'h60) / 4] = wd & 127;
                if (a == 'h7C) begin nalctl = wd & 255; if ((wd & 1) == 0) ngate = 0; end
                if (a == 'h30 && ((wd >> 4) & 1) == 1) begin nstat = 0; ngate = 0; end
            end
            if (fire) begin nalctl = nalctl & ~1; nstat = 1; ngate = 1; end
            mt = nt; ma = na; malctl = nalctl; mstat = nstat; mgate = ngate;
            mstop = nstop; mprog = nprog; madvd = (run && tick) ? 1 : 0;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // Every cycle: read data and interrupt against the model.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(cur_req, int'(reg_rdata), mread(int'(reg_addr)));
            chk(cur_req, int'(irq), (mstat == 1 && mgate == 1) ? 1 : 0);
        end
    end

    task automatic wr_reg(int a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(string req, int a, int exp);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'(a);
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic run_ticks(int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_time(int y, int mo, int d, int w, int h, int mi, int s);
        wr_reg('h40, y); wr_reg('h44, mo); wr_reg('h48, d); wr_reg('h4C, w);
        wr_reg('h50, h); wr_reg('h54, mi); wr_reg('h58, s);
    endtask

    task automatic step(int n);
        wr_reg('h20, 0);
        run_ticks(n);
        wr_reg('h20, 1);
    endtask

    task automatic unlock_all();
        for (int k = 0; k < 7; k++) wr_reg(4 + 4 * k, keys[k]);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R6";
        expect_reg("R6", 'h20, 1);
        expect_reg("R6", 'h40, 0);
        expect_reg("R6", 'h44, 1);
        expect_reg("R6", 'h48, 1);
        expect_reg("R6", 'h58, 0);
        expect_reg("R6", 'h7C, 0);
        expect_reg("R6", 'h30, 0);
        chk("R6", int'(irq), 0);

        cur_req = "R1";
        wr_reg('h20, 0);
        run_ticks(4);
        expect_reg("R1", 'h58, 0);
        wr_reg('h04, 'hC6); wr_reg('h08, 'h9A); wr_reg('h0C, 'h00);
        wr_reg('h10, 'hA3); wr_reg('h14, 'h57); wr_reg('h18, 'h67); wr_reg('h1C, 'hD2);
        run_ticks(3);
        expect_reg("R1", 'h58, 0);
        wr_reg('h04, 'hC6); wr_reg('h0C, 'h59);
        run_ticks(2);
        expect_reg("R1", 'h58, 0);
        unlock_all();
        run_ticks(3);
        expect_reg("R1", 'h58, 3);

        cur_req = "R2";
        wr_reg('h58, 40);
        expect_reg("R2", 'h58, 3);
        wr_reg('h20, 1);
        run_ticks(5);
        expect_reg("R2", 'h58, 3);

        cur_req = "R3";
        set_time(23, 6, 14, 6, 23, 59, 59);
        step(1);
        expect_reg("R3", 'h58, 0);
        expect_reg("R3", 'h54, 0);
        expect_reg("R3", 'h50, 0);
        expect_reg("R3", 'h4C, 0);
        expect_reg("R3", 'h48, 15);
        expect_reg("R3", 'h44, 6);
        expect_reg("R3", 'h40, 23);

        cur_req = "R4";
        set_time(0, 2, 28, 1, 23, 59, 59);
        step(1);
        expect_reg("R4", 'h44, 3);
        expect_reg("R4", 'h48, 1);
        set_time(4, 2, 28, 1, 23, 59, 59);
        step(1);
        expect_reg("R4", 'h44, 2);
        expect_reg("R4", 'h48, 29);
        set_time(4, 4, 30, 2, 23, 59, 59);
        step(1);
        expect_reg("R4", 'h44, 5);
        expect_reg("R4", 'h48, 1);
        set_time(7, 1, 31, 3, 23, 59, 59);
        step(1);
        expect_reg("R4", 'h44, 2);
        expect_reg("R4", 'h48, 1);

        cur_req = "R5";
        set_time(99, 12, 31, 5, 23, 59, 59);
        step(1);
        expect_reg("R5", 'h40, 0);
        expect_reg("R5", 'h44, 1);
        expect_reg("R5", 'h48, 1);

        cur_req = "R7";
        set_time(0, 1, 1, 0, 0, 0, 0);
        wr_reg('h78, 5);
        wr_reg('h74, 1);
        wr_reg('h7C, 'hC1);
        step(8);
        expect_reg("R7", 'h30, 0);
        chk("R7", int'(irq), 0);
        wr_reg('h7C, 'h81);
        wr_reg('h58, 0);
        step(10);
        expect_reg("R7", 'h30, 'h10);
        expect_reg("R7", 'h7C, 'h80);
        chk("R7", int'(irq), 1);

        cur_req = "R8";
        wr_reg('h30, 0);
        expect_reg("R8", 'h30, 'h10);
        wr_reg('h30, 'h10);
        expect_reg("R8", 'h30, 0);
        chk("R8", int'(irq), 0);

        cur_req = "R9";
        wr_reg('h58, 0);
        wr_reg('h7C, 'h81);
        step(7);
        chk("R9", int'(irq), 1);
        wr_reg('h7C, 0);
        chk("R9", int'(irq), 0);
        expect_reg("R9", 'h30, 'h10);
        wr_reg('h30, 'h10);

        cur_req = "R10";
        expect_reg("R10", 'h00, 0);
        expect_reg("R10", 'h04, 0);
        expect_reg("R10", 'h24, 0);
        expect_reg("R10", 'h78, 5);
        wr_reg('h58, 32'hFFFF_FF85);
        expect_reg("R10", 'h58, 5);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule